// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation at a time against a single synchronous memory port. A request carries a base address, a signed 16-bit displacement, an access width (32 or 64 bits), an 8-bit operation selector, a source operand and the current value of the comparison register (register zero). The unit forms the target address and holds the memory lock while it reads the location, derives the new value and writes it back. It then reports, for one cycle, the values that must be written into the source register and into register zero.

The selector's upper nibble picks the operation. Bit 0 is the fetch modifier, which returns the memory value from before the update. Requests that are misaligned or carry an unsupported selector are rejected with an error and touch no memory. The memory answers a read one cycle after `mem_rd_en`. For 32-bit accesses it places the addressed word in the low half of `mem_rdata`, and it writes only the addressed word.

Top module: `amo_unit`

## Requirements
- R1: Selector 0x00 (add) stores old + src at the target. The sum wraps at the access width.
- R2: Selectors 0x40 (or), 0x50 (and) and 0xa0 (xor) store the bitwise result of old and src.
- R3: With selector bit 0 (fetch) set, `src_we` pulses with `done` and `src_val` holds the pre-update memory value. With bit 0 clear, `src_we` stays low.
- R4: Selector 0xe1 (exchange) stores src and returns the old value through `src_we`/`src_val`.
- R5: Selector 0xf1 (compare-exchange) stores src when the old value equals r0. In that case it returns the old value on both `src_val` and `r0_val`, with `src_we` and `r0_we` high.
- R6: When compare-exchange finds old different from r0, no write occurs, but `r0_we` still pulses with the old value.
- R7: With `req_wide`=0, only the low 32 bits of src and r0 take part. Only the addressed 32-bit word of memory changes, and every returned value is zero-extended to 64 bits.
- R8: The target address is `req_base` plus the sign-extended `req_offset`.
- R9: A target that is not 8-byte aligned (64-bit) or 4-byte aligned (32-bit) ends the request with `err` high at `done` and makes no memory read or write.
- R10: Bits 3..1 of the selector must be zero, and the upper nibble must be 0, 4, 5, a, e or f. Nibbles e and f also require the fetch bit. Any other selector ends with `err` and makes no memory access.
- R11: An accepted request makes exactly one read and at most one write. `mem_lock` is high from the read cycle through the `done` cycle, which is 4 cycles, or 3 when compare-exchange fails.
- R12: `req_valid` is ignored while `busy` is high: it produces no extra result and no memory access.
- R13: After reset, `busy`, `done`, `mem_lock`, `mem_rd_en` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_base | input | AW | Base address |
| req_offset | input | OFS_W | Signed displacement |
| req_wide | input | 1 | 1: 64-bit access, 0: 32-bit |
| req_op | input | 8 | Operation selector |
| req_src | input | DW | Source register value |
| req_r0 | input | DW | Register zero value |
| busy | output | 1 | Operation in flight |
| mem_lock | output | 1 | Memory lock held |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wide | output | 1 | Access width to memory |
| mem_addr | output | AW | Byte address to memory |
| mem_wdata | output | DW | Write data (low half for 32-bit) |
| mem_rdata | input | DW | Read data, one cycle after read strobe |
| done | output | 1 | Result cycle |
| err | output | 1 | Request rejected (valid with done) |
| src_we | output | 1 | Source register update |
| src_val | output | DW | Value for source register |
| r0_we | output | 1 | Register zero update |
| r0_val | output | DW | Value for register zero |

## Verification
A fresh request can arrive in the same cycle that a locked read-modify-write is in flight. The bench provokes this by raising `req_valid` with a different target while the unit is in its read cycle. It judges the outcome through the scoreboard, which must see exactly one result, and by comparing the whole memory image with a shadow copy. Compare-exchange also reports both register results in the same `done` cycle. Each of the two results is checked against values computed by the bench.

// File: rtl/amo_unit.sv
module amo_unit #(
  parameter int AW    = 64,
  parameter int DW    = 64,
  parameter int OFS_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_base,
  input  logic [OFS_W-1:0] req_offset,
  input  logic          req_wide,
  input  logic [7:0]    req_op,
  input  logic [DW-1:0] req_src,
  input  logic [DW-1:0] req_r0,
  output logic          busy,
  output logic          mem_lock,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          err,
  output logic          src_we,
  output logic [DW-1:0] src_val,
  output logic          r0_we,
  output logic [DW-1:0] r0_val
);
  localparam int HW = DW / 2;
  localparam logic [3:0] C_ADD = 4'h0, C_OR = 4'h4, C_AND = 4'h5,
                         C_XOR = 4'ha, C_XCHG = 4'he, C_CMPX = 4'hf;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MOD, S_WRITE, S_DONE} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [3:0]    code_q;
  logic          wide_q, fetch_q, err_q;
  logic [DW-1:0] src_q, r0_q, old_q, new_q;

  function automatic logic [DW-1:0] zx(input logic [DW-1:0] v);
    return {{(DW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  logic [AW-1:0] tgt;
  logic [3:0]    rcode;
  logic          simple, swap, op_ok, algn_ok;
  assign tgt     = req_base + {{(AW-OFS_W){req_offset[OFS_W-1]}}, req_offset};
  assign rcode   = req_op[7:4];
  assign simple  = rcode == C_ADD || rcode == C_OR || rcode == C_AND || rcode == C_XOR;
  assign swap    = rcode == C_XCHG || rcode == C_CMPX;
  assign op_ok   = req_op[3:1] == 3'b000 && (simple || (swap && req_op[0]));
  assign algn_ok = req_wide ? tgt[2:0] == 3'b000 : tgt[1:0] == 2'b00;

  logic [DW-1:0] rd_v, calc, calc_m;
  logic          hit;
  assign rd_v = wide_q ? mem_rdata : zx(mem_rdata);
  assign hit  = rd_v == r0_q;

  always_comb begin
    case (code_q)
      C_ADD:   calc = rd_v + src_q;
      C_OR:    calc = rd_v | src_q;
      C_AND:   calc = rd_v & src_q;
      C_XOR:   calc = rd_v ^ src_q;
      default: calc = src_q;
    endcase
  end
  assign calc_m = wide_q ? calc : zx(calc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      code_q  <= '0;
      wide_q  <= 1'b0;
      fetch_q <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= tgt;
          wide_q  <= req_wide;
          code_q  <= rcode;
          fetch_q <= req_op[0];
          src_q   <= req_wide ? req_src : zx(req_src);
          r0_q    <= req_wide ? req_r0 : zx(req_r0);
          old_q   <= '0;
          if (op_ok && algn_ok) begin
            err_q <= 1'b0;
            st    <= S_READ;
          end else begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end
        end
        S_READ: st <= S_MOD;
        S_MOD: begin
          old_q <= rd_v;
          new_q <= calc_m;
          st    <= (code_q == C_CMPX && !hit) ? S_DONE : S_WRITE;
        end
        S_WRITE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign err       = done && err_q;
  assign mem_rd_en = st == S_READ;
  assign mem_wr_en = st == S_WRITE;
  assign mem_lock  = st == S_READ || st == S_MOD || st == S_WRITE || (done && !err_q);
  assign mem_wide  = wide_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign src_we    = done && !err_q && fetch_q;
  assign r0_we     = done && !err_q && code_q == C_CMPX;
  assign src_val   = old_q;
  assign r0_val    = old_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mem_lock,
  input logic mem_rd_en,
  input logic mem_wr_en,
  input logic done,
  input logic err,
  input logic src_we,
  input logic r0_we
);
  p_rd_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_lock && busy);
  p_wr_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_lock);
  p_rd_then_modify_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_lock && !mem_rd_en && !mem_wr_en);
  p_wr_then_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> done && !err);
  p_err_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> !$past(mem_rd_en) && !$past(mem_wr_en) && !mem_lock);
  p_fetch_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_we |-> done && !err);
  p_r0_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> done && !err);
  p_single_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
endmodule

bind amo_unit amo_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_lock(mem_lock),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .done(done), .err(err),
  .src_we(src_we), .r0_we(r0_we)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_wide = 1'b0;
  logic [63:0] req_base = '0, req_src = '0, req_r0 = '0;
  logic [15:0] req_offset = '0;
  logic [7:0]  req_op = '0;
  logic        busy, mem_lock, mem_rd_en, mem_wr_en, mem_wide, done, err, src_we, r0_we;
  logic [63:0] mem_addr, mem_wdata, src_val, r0_val;
  logic [63:0] mem_rdata = '0;

  amo_unit dut_i (.*);

  logic [63:0] mem [16];
  logic [63:0] shadow [16];
  int rd_cnt = 0, wr_cnt = 0, lock_cnt = 0;

  always @(posedge clk) begin
    if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1;
      mem_rdata <= mem_wide ? mem[mem_addr[6:3]] :
                   (mem_addr[2] ? {32'h0, mem[mem_addr[6:3]][63:32]}
                                : {32'h0, mem[mem_addr[6:3]][31:0]});
    end
    if (mem_wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (mem_wide) mem[mem_addr[6:3]] <= mem_wdata;
      else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
      else mem[mem_addr[6:3]][31:0] <= mem_wdata[31:0];
    end
    if (mem_lock) lock_cnt <= lock_cnt + 1;
  end

  int vectors = 0, miscompares = 0;
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct { bit e; bit swe; logic [63:0] sv; bit rwe; logic [63:0] rv; string tag; } exp_t;
  exp_t q [$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R12 unexpected result", 64'd1, 64'd0);
      else begin
        exp_t x;
        x = q.pop_front();
        chk(err == x.e, {x.tag, " err"}, 64'(err), 64'(x.e));
        chk(src_we == x.swe, {x.tag, " src_we"}, 64'(src_we), 64'(x.swe));
        if (x.swe) chk(src_val == x.sv, {x.tag, " src_val"}, src_val, x.sv);
        chk(r0_we == x.rwe, {x.tag, " r0_we"}, 64'(r0_we), 64'(x.rwe));
        if (x.rwe) chk(r0_val == x.rv, {x.tag, " r0_val"}, r0_val, x.rv);
      end
    end
  end

  task automatic do_op(input string tag, input logic [63:0] base, input logic [15:0] off,
                       input bit wide, input logic [7:0] op, input logic [63:0] src,
                       input logic [63:0] r0, input bit inject);
    logic [63:0] a, old, s, r, nv;
    bit ok, wr, fetch;
    logic [3:0] c;
    exp_t x;
    int rd0, wr0, lk0, n;
    a = base + {{48{off[15]}}, off};
    c = op[7:4];
    fetch = op[0];
    ok = (op[3:1] == 3'b0) &&
         ((c == 4'h0 || c == 4'h4 || c == 4'h5 || c == 4'ha) ||
          ((c == 4'he || c == 4'hf) && fetch)) &&
         (wide ? a[2:0] == 3'b0 : a[1:0] == 2'b0);
    old = wide ? shadow[a[6:3]] : {32'h0, (a[2] ? shadow[a[6:3]][63:32] : shadow[a[6:3]][31:0])};
    s = wide ? src : {32'h0, src[31:0]};
    r = wide ? r0 : {32'h0, r0[31:0]};
    case (c)
      4'h0: nv = old + s;
      4'h4: nv = old | s;
      4'h5: nv = old & s;
      4'ha: nv = old ^ s;
      default: nv = s;
    endcase
    if (!wide) nv = {32'h0, nv[31:0]};
    wr = ok && !(c == 4'hf && old != r);
    x.e = !ok; x.swe = ok && fetch; x.sv = old;
    x.rwe = ok && c == 4'hf; x.rv = old; x.tag = tag;
    q.push_back(x);
    if (wr) begin
      if (wide) shadow[a[6:3]] = nv;
      else if (a[2]) shadow[a[6:3]][63:32] = nv[31:0];
      else shadow[a[6:3]][31:0] = nv[31:0];
    end
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; lk0 = lock_cnt;
    req_valid = 1'b1; req_base = base; req_offset = off; req_wide = wide;
    req_op = op; req_src = src; req_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      req_valid = 1'b1; req_base = 64'h28; req_offset = '0; req_wide = 1'b1;
      req_op = 8'h00; req_src = 64'h5555;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 50) begin @(negedge clk); n++; end
    chk(n < 50, {tag, " done timeout"}, 64'(n), 64'd0);
    @(negedge clk);
    chk(rd_cnt - rd0 == (ok ? 1 : 0), {tag, " R11 read count"}, 64'(rd_cnt - rd0), 64'(ok ? 1 : 0));
    chk(wr_cnt - wr0 == (wr ? 1 : 0), {tag, " R11 write count"}, 64'(wr_cnt - wr0), 64'(wr ? 1 : 0));
    chk(lock_cnt - lk0 == (!ok ? 0 : (wr ? 4 : 3)), {tag, " R11 lock cycles"},
        64'(lock_cnt - lk0), 64'(!ok ? 0 : (wr ? 4 : 3)));
    for (int i = 0; i < 16; i++)
      chk(mem[i] == shadow[i], {tag, " memory image"}, mem[i], shadow[i]);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 64'h0123_4567_89ab_cdef ^ (64'(i) * 64'h1111_0000_0101_0011);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_lock && !mem_rd_en && !mem_wr_en, "R13 reset state",
        {59'h0, busy, done, mem_lock, mem_rd_en, mem_wr_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_lock, "R13 idle after reset", {61'h0, busy, done, mem_lock}, 64'h0);

    do_op("R1 add fetch 64",   64'h00, 16'h0000, 1, 8'h01, 64'hffff_ffff_ffff_fff0, 0, 0);
    do_op("R1 add wrap 64",    64'h08, 16'h0000, 1, 8'h00, 64'hffff_ffff_ffff_ffff, 0, 0);
    do_op("R2 or no fetch",    64'h10, 16'h0000, 1, 8'h40, 64'hf000_0000_0000_000f, 0, 0);
    do_op("R2 and fetch",      64'h18, 16'h0000, 1, 8'h51, 64'h00ff_00ff_00ff_00ff, 0, 0);
    do_op("R2 xor fetch",      64'h20, 16'h0000, 1, 8'ha1, 64'hdead_beef_cafe_f00d, 0, 0);
    do_op("R3 xor no fetch",   64'h20, 16'h0000, 1, 8'ha0, 64'h1, 0, 0);
    do_op("R4 exchange",       64'h30, 16'h0000, 1, 8'he1, 64'h1234_5678_9abc_def0, 0, 0);
    shadow[7] = 64'h0000_0000_0000_0077; mem[7] = shadow[7];
    do_op("R5 cmpxchg match",  64'h38, 16'h0000, 1, 8'hf1, 64'haaaa, 64'h77, 0);
    do_op("R6 cmpxchg miss",   64'h38, 16'h0000, 1, 8'hf1, 64'hbbbb, 64'h77, 0);
    shadow[8] = 64'h1357_9bdf_ffff_ffff; mem[8] = shadow[8];
    do_op("R7 add 32 carry",   64'h40, 16'h0000, 0, 8'h01, 64'hffff_ffff_0000_0002, 0, 0);
    do_op("R7 xor 32 upper",   64'h44, 16'h0000, 0, 8'ha1, 64'h5a5a_5a5a_0f0f_0f0f, 0, 0);
    do_op("R7 cmpxchg 32",     64'h40, 16'h0000, 0, 8'hf1, 64'h9999_0000_4444_4444,
          64'hffff_ffff_0000_0001, 0);
    do_op("R8 negative offset",64'h58, 16'hfff8, 1, 8'h41, 64'h8000, 0, 0);
    do_op("R8 positive offset",64'h40, 16'h0014, 0, 8'h01, 64'h3, 0, 0);
    do_op("R9 misaligned 64",  64'h04, 16'h0000, 1, 8'h01, 64'h1, 0, 0);
    do_op("R9 misaligned 32",  64'h10, 16'h0002, 0, 8'h00, 64'h1, 0, 0);
    do_op("R10 xchg no fetch", 64'h00, 16'h0000, 1, 8'he0, 64'h1, 0, 0);
    do_op("R10 unknown code",  64'h00, 16'h0000, 1, 8'h11, 64'h1, 0, 0);
    do_op("R10 stray bits",    64'h00, 16'h0000, 1, 8'h02, 64'h1, 0, 0);
    do_op("R12 busy inject",   64'h60, 16'h0000, 1, 8'h01, 64'h10, 0, 1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12 pending results", 64'(q.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      chk(0, "watchdog expired", 64'd1, 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule